// File: doc/BRIEF.md
# Block-Lock Write Protection Unit

This unit owns the one-byte protection control register of a small serial-access nonvolatile memory. It also decides, for every target address, whether a write may proceed. An upstream command sequencer supplies three things: the current target address, a strobe for each byte it loads into the register, and a strobe when the start-commit command arrives. The page buffer reads back two permit signals. One permits a write to the array address on the bus. The other permits a write to the register.

The register holds three live bits. A two-bit protection level guards none, the top quarter, the top half or all of the array. A pin-enable bit lets a low level on the external write-protect pin freeze the register. Array protection follows the level alone, whatever the pin does. The pin only ever guards the register. Because the guard also covers the pin-enable bit, the lock holds for as long as the pin stays low. The register sits at address FFFFh, outside the array. A read of the register returns its value as the first byte and zeros after that. Storage is flops that change only when a commit succeeds.

Top module: `wpu_guard`

## Requirements
- R1: After reset the register reads 00h, every array address is write-permitted and a register write is permitted.
- R2: The first byte read from the register shows pin-enable at bit 7, level bit 1 at bit 3 and level bit 0 at bit 2. Every other bit reads 0 and is stored as 0 whatever was loaded.
- R3: Each read strobe after a sequence restart moves past the first byte. Every byte after the first reads 00h until the next restart.
- R4: A loaded byte leaves the register unchanged until a start-commit strobe follows it in the same sequence.
- R5: If two or more bytes are loaded in one sequence, the following commit leaves the register unchanged.
- R6: Level 01 blocks array writes to addresses whose two top array-address bits are 11 (0600h–07FFh for 2K bytes). All lower addresses stay permitted.
- R7: Level 10 blocks array writes where the top array-address bit is 1 (0400h–07FFh for 2K bytes). All lower addresses stay permitted.
- R8: Level 11 blocks every array address. Level 00 blocks none.
- R9: Addresses at or beyond the array size, including the register address FFFFh, are never array-write-permitted.
- R10: With the pin low and pin-enable 1, the register write permit is 0 and a commit leaves the register unchanged. This includes an attempt to clear pin-enable.
- R11: With pin-enable 0, a low pin does not block register writes.
- R12: The array write permit does not depend on the pin.
- R13: If the lock becomes active at any point between loading a byte and its commit, that load is cancelled, even when the pin returns high before the commit.
- R14: Once a commit has been accepted, a later low on the pin does not undo the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wp_pin_i | input | 1 | External write-protect pin level (low requests protection) |
| addr_i | input | 16 | Target address of the current access |
| seq_clr_i | input | 1 | Restarts a command sequence: clears the byte count, the pending load and the read position |
| reg_ld_i | input | 1 | Loads one byte aimed at the register |
| reg_ld_data_i | input | 8 | Byte to load |
| commit_i | input | 1 | Start-commit command |
| rd_byte_i | input | 1 | Consumes one byte of a register read |
| rd_data_o | output | 8 | Register read byte |
| arr_wr_ok_o | output | 1 | Write to addr_i in the array is permitted |
| reg_wr_ok_o | output | 1 | Write to the register is permitted |

## Verification
The assertions assume that the sequencer restarts a sequence before any register load or read. They also assume that a load and a commit never arrive in the same cycle. The bench keeps every strobe one cycle wide and raises at most one strobe per cycle. It restarts each sequence before loading. The pin changes only between strobes, so each lock scenario sets a clear order of pin level, load and commit.

// File: rtl/wpu_pkg.sv
// Shared definitions for the block-lock write protection unit.
// Assumes a 16-bit address space with the control register at its top address.
package wpu_pkg;

    localparam int          ADDR_W    = 16;
    localparam logic [15:0] CTL_ADDR  = 16'hFFFF;
    localparam int          PEN_BIT   = 7;
    localparam int          LVL1_BIT  = 3;
    localparam int          LVL0_BIT  = 2;
    localparam logic [7:0]  LIVE_MASK = 8'h8C;

    typedef enum logic [1:0] {
        LVL_NONE    = 2'b00,
        LVL_QUARTER = 2'b01,
        LVL_HALF    = 2'b10,
        LVL_ALL     = 2'b11
    } lock_lvl_e;

    typedef struct packed {
        logic      pin_en;
        lock_lvl_e lvl;
    } ctl_t;

    // Pulls the live fields out of a loaded byte; dead bits are dropped.
    function automatic ctl_t byte_to_ctl(input logic [7:0] b);
        ctl_t c;
        c.pin_en = b[PEN_BIT];
        c.lvl    = lock_lvl_e'({b[LVL1_BIT], b[LVL0_BIT]});
        return c;
    endfunction

    // Places the live fields at their bit positions; dead bits read as zero.
    function automatic logic [7:0] ctl_to_byte(input ctl_t c);
        logic [7:0] b;
        b           = 8'h00;
        b[PEN_BIT]  = c.pin_en;
        b[LVL1_BIT] = c.lvl[1];
        b[LVL0_BIT] = c.lvl[0];
        return b;
    endfunction

endpackage

// File: rtl/wpu_region_chk.sv
// Decides whether an array address may be written under the current lock level.
// Assumes ARRAY_BYTES is a power of two no smaller than 4 and no larger than 32K.
// The quarter and half boundaries come from the two top array-address bits.
module wpu_region_chk
    import wpu_pkg::*;
#(
    parameter int ARRAY_BYTES = 2048
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  lock_lvl_e         lvl_i,
    output logic              permit_o
);
    localparam int              AW    = $clog2(ARRAY_BYTES);
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(ARRAY_BYTES);

    logic       in_array;
    logic [1:0] top2;
    logic       guarded;

    // Picks the two top array-address bits for this array size.
    generate
        if (AW >= 2) begin : g_top
            assign top2 = addr_i[AW-1 -: 2];
        end else begin : g_tiny
            assign top2 = 2'b11;
        end
    endgenerate

    // Classifies the address against the array end and the lock level.
    always_comb begin
        in_array = ({1'b0, addr_i} < LIMIT);
        unique case (lvl_i)
            LVL_NONE:    guarded = 1'b0;
            LVL_QUARTER: guarded = (top2 == 2'b11);
            LVL_HALF:    guarded = top2[1];
            default:     guarded = 1'b1;
        endcase
        permit_o = in_array && !guarded;
    end

endmodule

// File: rtl/wpu_stage.sv
// Holds a register byte loaded by the sequencer until commit.
// Aborts on a second byte in one sequence and cancels on an active pin lock.
// Assumes load and commit strobes are never raised in the same cycle.
module wpu_stage
    import wpu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       seq_clr_i,
    input  logic       ld_i,
    input  logic [7:0] ld_data_i,
    input  logic       commit_i,
    input  logic       hw_lock_i,
    output ctl_t       pend_o,
    output logic       commit_ok_o
);
    logic seen_q;
    logic pend_v_q;
    ctl_t pend_q;

    // Tracks the byte count, pending value and its validity across a sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q   <= 1'b0;
            pend_v_q <= 1'b0;
            pend_q   <= '0;
        end else if (seq_clr_i || commit_i) begin
            seen_q   <= 1'b0;
            pend_v_q <= 1'b0;
        end else if (ld_i) begin
            seen_q <= 1'b1;
            if (!seen_q) begin
                pend_q   <= byte_to_ctl(ld_data_i);
                pend_v_q <= !hw_lock_i;
            end else begin
                pend_v_q <= 1'b0;
            end
        end else if (hw_lock_i) begin
            pend_v_q <= 1'b0;
        end
    end

    // Accepts a commit only for an intact single byte with the lock released.
    always_comb begin
        commit_ok_o = commit_i && pend_v_q && !hw_lock_i;
        pend_o      = pend_q;
    end

    // R5
    second_byte_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_i && seen_q && !seq_clr_i && !commit_i) |=> !pend_v_q);

    // R13
    lock_cancels_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_lock_i |=> !pend_v_q);

endmodule

// File: rtl/wpu_ctl_store.sv
// The control register flops and the byte-wise register read path.
// Assumes the read position is restarted by the sequence-restart strobe.
module wpu_ctl_store
    import wpu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       commit_ok_i,
    input  ctl_t       pend_i,
    input  logic       hw_lock_i,
    input  logic       seq_clr_i,
    input  logic       rd_byte_i,
    output ctl_t       ctl_o,
    output logic [7:0] rd_data_o
);
    ctl_t ctl_q;
    logic past_first_q;

    // Updates the register only on an accepted commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (commit_ok_i) begin
            ctl_q <= pend_i;
        end
    end

    // Remembers whether the first read byte has been consumed.
    always_ff @(posedge clk) begin
        if (!rst_n || seq_clr_i) begin
            past_first_q <= 1'b0;
        end else if (rd_byte_i) begin
            past_first_q <= 1'b1;
        end
    end

    // Drives the register image on the first byte and zero afterwards.
    always_comb begin
        ctl_o     = ctl_q;
        rd_data_o = past_first_q ? 8'h00 : ctl_to_byte(ctl_q);
    end

    // R10
    no_change_under_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctl_q) |-> $past(!hw_lock_i));

endmodule

// File: rtl/wpu_guard.sv
// Top of the block-lock write protection unit: combines the pin with the
// pin-enable bit, stages register loads, stores the register and grants
// array and register write permits. Assumes a sequencer restarts each
// command sequence with seq_clr_i before loads or reads.
module wpu_guard
    import wpu_pkg::*;
#(
    parameter int ARRAY_BYTES = 2048
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wp_pin_i,
    input  logic [15:0] addr_i,
    input  logic        seq_clr_i,
    input  logic        reg_ld_i,
    input  logic [7:0]  reg_ld_data_i,
    input  logic        commit_i,
    input  logic        rd_byte_i,
    output logic [7:0]  rd_data_o,
    output logic        arr_wr_ok_o,
    output logic        reg_wr_ok_o
);
    ctl_t ctl;
    ctl_t pend;
    logic commit_ok;
    logic hw_lock;

    // Pin protection applies only with the pin low and pin-enable set.
    always_comb begin
        hw_lock     = !wp_pin_i && ctl.pin_en;
        reg_wr_ok_o = !hw_lock;
    end

    wpu_stage u_stage (
        .clk         (clk),
        .rst_n       (rst_n),
        .seq_clr_i   (seq_clr_i),
        .ld_i        (reg_ld_i),
        .ld_data_i   (reg_ld_data_i),
        .commit_i    (commit_i),
        .hw_lock_i   (hw_lock),
        .pend_o      (pend),
        .commit_ok_o (commit_ok)
    );

    wpu_ctl_store u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit_ok_i (commit_ok),
        .pend_i      (pend),
        .hw_lock_i   (hw_lock),
        .seq_clr_i   (seq_clr_i),
        .rd_byte_i   (rd_byte_i),
        .ctl_o       (ctl),
        .rd_data_o   (rd_data_o)
    );

    wpu_region_chk #(.ARRAY_BYTES(ARRAY_BYTES)) u_region (
        .addr_i   (addr_i),
        .lvl_i    (ctl.lvl),
        .permit_o (arr_wr_ok_o)
    );

    // R9
    reg_addr_not_array_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == CTL_ADDR) |-> !arr_wr_ok_o);

    // R8
    full_lock_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_o[LVL1_BIT] && rd_data_o[LVL0_BIT]) |-> !arr_wr_ok_o);

    // R2
    dead_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_o & ~LIVE_MASK) == 8'h00);

    // R3
    later_bytes_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_byte_i && !seq_clr_i) |=> (rd_data_o == 8'h00));

endmodule

// File: tb/wpu_guard_test.sv
module wpu_guard_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wp_pin = 1'b1;
    logic [15:0] addr = 16'h0000;
    logic        seq_clr = 1'b0;
    logic        reg_ld = 1'b0;
    logic [7:0]  reg_ld_data = 8'h00;
    logic        commit = 1'b0;
    logic        rd_byte = 1'b0;
    logic [7:0]  rd_data;
    logic        arr_ok;
    logic        reg_ok;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        string      req;
        int         kind;
        logic [7:0] exp;
    } item_t;
    item_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    wpu_guard #(.ARRAY_BYTES(2048)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .wp_pin_i      (wp_pin),
        .addr_i        (addr),
        .seq_clr_i     (seq_clr),
        .reg_ld_i      (reg_ld),
        .reg_ld_data_i (reg_ld_data),
        .commit_i      (commit),
        .rd_byte_i     (rd_byte),
        .rd_data_o     (rd_data),
        .arr_wr_ok_o   (arr_ok),
        .reg_wr_ok_o   (reg_ok)
    );

    // Monitor: pops expected items and compares them with the outputs.
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = sb.pop_front();
            case (it.kind)
                0: act = rd_data;
                1: act = {7'b0, arr_ok};
                default: act = {7'b0, reg_ok};
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.req, it.kind, act, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic restart();
        seq_clr = 1'b1; tick(); seq_clr = 1'b0;
    endtask

    task automatic load(input logic [7:0] b);
        reg_ld = 1'b1; reg_ld_data = b; tick(); reg_ld = 1'b0;
    endtask

    task automatic do_commit();
        commit = 1'b1; tick(); commit = 1'b0;
    endtask

    task automatic push_wait(input string req, input int kind, input logic [7:0] exp);
        item_t it;
        it.req = req; it.kind = kind; it.exp = exp;
        sb.push_back(it);
        @(negedge clk);
        #1;
    endtask

    task automatic exp_reg(input string req, input logic [7:0] exp);
        push_wait(req, 0, exp);
    endtask

    task automatic exp_arr(input string req, input logic [15:0] a, input logic exp);
        addr = a;
        push_wait(req, 1, {7'b0, exp});
    endtask

    task automatic exp_regok(input string req, input logic exp);
        push_wait(req, 2, {7'b0, exp});
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        exp_reg("R1", 8'h00);
        exp_arr("R1", 16'h07FF, 1'b1);
        exp_regok("R1", 1'b1);
        // R4 load without commit, then commit
        restart(); load(8'h04);
        exp_reg("R4", 8'h00);
        do_commit();
        exp_reg("R4", 8'h04);
        // R6 upper quarter
        exp_arr("R6", 16'h05FF, 1'b1);
        exp_arr("R6", 16'h0600, 1'b0);
        exp_arr("R6", 16'h07FF, 1'b0);
        // R3 second byte reads zero
        rd_byte = 1'b1; tick(); rd_byte = 1'b0;
        exp_reg("R3", 8'h00);
        restart();
        exp_reg("R3", 8'h04);
        // R2 dead bits dropped; R8 full lock
        restart(); load(8'hFF); do_commit();
        exp_reg("R2", 8'h8C);
        exp_arr("R8", 16'h0000, 1'b0);
        exp_arr("R8", 16'h07FF, 1'b0);
        // R10 pin low with pin-enable set locks the register
        wp_pin = 1'b0; tick();
        exp_regok("R10", 1'b0);
        restart(); load(8'h00); do_commit();
        exp_reg("R10", 8'h8C);
        // R12 array permit follows level only
        exp_arr("R12", 16'h0000, 1'b0);
        // R7 upper half
        wp_pin = 1'b1; tick();
        restart(); load(8'h08); do_commit();
        exp_reg("R7", 8'h08);
        exp_arr("R7", 16'h03FF, 1'b1);
        exp_arr("R7", 16'h0400, 1'b0);
        // R11 pin low ignored when pin-enable is 0
        wp_pin = 1'b0; tick();
        exp_regok("R11", 1'b1);
        restart(); load(8'h00); do_commit();
        exp_reg("R11", 8'h00);
        // R8 no lock, R9 outside array, R12 pin low
        exp_arr("R8", 16'h07FF, 1'b1);
        exp_arr("R12", 16'h0000, 1'b1);
        exp_arr("R9", 16'h0800, 1'b0);
        exp_arr("R9", 16'hFFFF, 1'b0);
        // R5 two bytes abort the commit
        wp_pin = 1'b1; tick();
        restart(); load(8'h04); load(8'h08); do_commit();
        exp_reg("R5", 8'h00);
        // R13 pin pulse between load and commit cancels it
        restart(); load(8'h84); do_commit();
        exp_reg("R13", 8'h84);
        restart(); load(8'h00);
        wp_pin = 1'b0; tick(); wp_pin = 1'b1; tick();
        do_commit();
        exp_reg("R13", 8'h84);
        // R14 pin low right after an accepted commit
        restart(); load(8'h00); do_commit();
        wp_pin = 1'b0; tick(); tick();
        exp_reg("R14", 8'h00);
        exp_regok("R14", 1'b1);
        wp_pin = 1'b1; tick();
        tick();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule